// File: doc/BRIEF.md
# Pulse Width Measurement Timer Channel

This block is one 16-bit timer channel that measures how long an input pin stays at a chosen level. Software picks one of two prescaled counting clocks and the level to measure, high or low. It then arms the channel with a start trigger. The channel waits for the edge that begins the chosen level, clears its counter and counts prescaled ticks. On the opposite edge it copies the count into a capture register. It also decides whether the counter wrapped during that measurement and raises a one-cycle interrupt. After that the counter freezes until the next start edge, so back-to-back pulses are measured without further software action.

A stop trigger disarms the channel. The counter and the overflow flag keep their last values. The configuration registers accept writes only while the channel is disarmed. A unit enable input acts as the clock and power gate of the channel: while it is low, every register is held at its default and no write is accepted.

Top module: `pulse_width_timer`

## Requirements
- R1: A one-cycle pulse on `startTrig` sets the enable status bit and arms the channel. The counter keeps its previous value until a start edge is seen.
- R2: Two flops synchronise `pinIn` before edge detection. The start edge clears the counter to 0. If the pin holds the measured level for W clocks, the capture value is floor((W-1)/(N+1)), where N is the ratio of the selected prescaler. That prescaler produces one tick every N+1 clocks, and its phase restarts on the start edge.
- R3: At every capture, the overflow status bit is set if the counter wrapped from FFFFh to 0000h during that measurement, and cleared otherwise.
- R4: Each capture updates the capture register and drives `irq` high for exactly one clock.
- R5: After a capture the counter stops and holds its value until the next start edge.
- R6: A one-cycle pulse on `stopTrig` clears the enable status bit and halts counting. The counter and the overflow bit keep their values, and a later capture-level edge produces neither a capture nor an interrupt. If both triggers arrive in the same clock, the stop wins.
- R7: While the channel is enabled, writes to the mode and prescaler registers are ignored. They take effect when the channel is disabled.
- R8: The counter can be read at any time, and it advances while a measurement runs.
- R9: Mode bit 0 selects the counting clock: 0 selects prescaler A and 1 selects prescaler B.
- R10: Mode bit 1 selects the measured level. With 0 the channel measures high width: a rising edge starts and a falling edge captures. With 1 the channel measures low width and the edges are swapped.
- R11: While `unitEn` is low, all channel state is at its default (every register reads 0) and writes are blocked.
- R12: Register map on `wrAddr`/`rdAddr`:
  - 0: mode, bits [1:0].
  - 1: prescaler A ratio, 8 bits.
  - 2: prescaler B ratio, 8 bits.
  - 3: counter, read only.
  - 4: capture, read only.
  - 5: status, read only; bit 0 is enable and bit 1 is overflow.
  - Any other address reads 0.

Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| unitEn | input | 1 | Unit enable; low holds the channel in its default state |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 16 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 16 | Register read data |
| startTrig | input | 1 | Arm pulse |
| stopTrig | input | 1 | Disarm pulse |
| pinIn | input | 1 | Asynchronous measured input |
| irq | output | 1 | One-cycle capture interrupt |

## Verification
The hardest case to reach is a counter wrap inside one measurement. To get there, the bench holds the pin high for more than 65536 ticks with the divide-by-one prescaler and checks that the overflow bit is set. A short pulse follows, which must clear the bit again. The bench then stops the channel in the middle of the next measurement and confirms that the set overflow bit and the frozen counter both survive the stop. Every pulse length is driven on the falling clock edge, so the two-flop synchroniser latency is fixed and the expected capture values are exact.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] ADDR_MODE   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_PRE_A  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_PRE_B  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CAPT   = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd5;

  // strobes from control to datapath
  typedef struct packed {
    logic clearCnt;
    logic countEn;
    logic doCapture;
    logic cfgLock;
  } pwtStrobe_t;
endpackage

// File: rtl/pwt_prescaler.sv
module pwt_prescaler #(
  parameter int RATIO_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               run,
  input  logic               restart,
  input  logic [RATIO_W-1:0] ratio,
  output logic               tick
);
  logic [RATIO_W-1:0] phase;

  assign tick = run && (phase == ratio);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       phase <= '0;
    else if (!run || restart)        phase <= '0;
    else if (phase == ratio)         phase <= '0;
    else                             phase <= phase + 1'b1;
  end
endmodule

// File: rtl/pwt_ctrl.sv
module pwt_ctrl
  import pwt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       unitEn,
  input  logic       startTrig,
  input  logic       stopTrig,
  input  logic       pinIn,
  input  logic       lowLevel,
  output pwtStrobe_t strobe,
  output logic       irq
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_COUNT} state_t;

  state_t state, stateNext;
  logic   syncA, syncB, prevB;
  logic   riseEdge, fallEdge, startEdge, capEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0; syncB <= 1'b0; prevB <= 1'b0;
    end else if (!unitEn) begin
      syncA <= 1'b0; syncB <= 1'b0; prevB <= 1'b0;
    end else begin
      syncA <= pinIn; syncB <= syncA; prevB <= syncB;
    end
  end

  always_comb begin
    riseEdge  = syncB && !prevB;
    fallEdge  = !syncB && prevB;
    startEdge = lowLevel ? fallEdge : riseEdge;
    capEdge   = lowLevel ? riseEdge : fallEdge;

    strobe.clearCnt  = (state == S_WAIT) && startEdge && !stopTrig;
    strobe.doCapture = (state == S_COUNT) && capEdge && !stopTrig;
    strobe.countEn   = (state == S_COUNT) && !capEdge && !stopTrig;
    strobe.cfgLock   = (state != S_IDLE);

    stateNext = state;
    if (stopTrig)                              stateNext = S_IDLE;
    else if (startTrig)                        stateNext = S_WAIT;
    else if (state == S_WAIT && startEdge)     stateNext = S_COUNT;
    else if (state == S_COUNT && capEdge)      stateNext = S_WAIT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; irq <= 1'b0;
    end else if (!unitEn) begin
      state <= S_IDLE; irq <= 1'b0;
    end else begin
      state <= stateNext; irq <= strobe.doCapture;
    end
  end

  // R4: interrupt lasts a single cycle
  a_r4_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);
  // R6: stop trigger disarms the channel
  a_r6_stop_disarms: assert property (@(posedge clk) disable iff (!rstN)
    stopTrig |=> !strobe.cfgLock);
  // R1: start trigger arms the channel
  a_r1_start_arms: assert property (@(posedge clk) disable iff (!rstN || !unitEn)
    (startTrig && !stopTrig) |=> strobe.cfgLock);
endmodule

// File: rtl/pwt_datapath.sv
module pwt_datapath
  import pwt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int RATIO_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              unitEn,
  input  pwtStrobe_t        strobe,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              lowLevel
);
  localparam int NUM_SRC = 2;

  logic [1:0]         modeQ;
  logic [RATIO_W-1:0] ratioQ [NUM_SRC];
  logic [NUM_SRC-1:0] tickV;
  logic [CNT_W-1:0]   cntQ, capQ;
  logic               wrapSeen, ovfQ, tickSel, wrOk;

  assign wrOk     = wrEn && unitEn && !strobe.cfgLock;
  assign lowLevel = modeQ[1];
  assign tickSel  = tickV[modeQ[0]];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                modeQ <= '0;
    else if (!unitEn)                         modeQ <= '0;
    else if (wrOk && wrAddr == ADDR_MODE)     modeQ <= wrData[1:0];
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_PRE_A + ADDR_W'(i);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                            ratioQ[i] <= '0;
      else if (!unitEn)                     ratioQ[i] <= '0;
      else if (wrOk && wrAddr == MY_ADDR)   ratioQ[i] <= wrData[RATIO_W-1:0];
    end

    pwt_prescaler #(.RATIO_W(RATIO_W)) i_pre (
      .clk     (clk),
      .rstN    (rstN),
      .run     (unitEn),
      .restart (strobe.clearCnt),
      .ratio   (ratioQ[i]),
      .tick    (tickV[i])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0; capQ <= '0; wrapSeen <= 1'b0; ovfQ <= 1'b0;
    end else if (!unitEn) begin
      cntQ <= '0; capQ <= '0; wrapSeen <= 1'b0; ovfQ <= 1'b0;
    end else begin
      if (strobe.clearCnt) begin
        cntQ     <= '0;
        wrapSeen <= 1'b0;
      end else if (strobe.countEn && tickSel) begin
        cntQ <= cntQ + 1'b1;
        if (&cntQ) wrapSeen <= 1'b1;
      end
      if (strobe.doCapture) begin
        capQ <= cntQ;
        ovfQ <= wrapSeen;
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_MODE:   rdData = DATA_W'(modeQ);
      ADDR_PRE_A:  rdData = DATA_W'(ratioQ[0]);
      ADDR_PRE_B:  rdData = DATA_W'(ratioQ[1]);
      ADDR_COUNT:  rdData = DATA_W'(cntQ);
      ADDR_CAPT:   rdData = DATA_W'(capQ);
      ADDR_STATUS: rdData = DATA_W'({ovfQ, strobe.cfgLock});
      default:     rdData = '0;
    endcase
  end

  // R2: start edge zeroes the counter
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rstN || !unitEn)
    strobe.clearCnt |=> (cntQ == '0));
  // R5: counter frozen while not counting
  a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rstN || !unitEn)
    (!strobe.countEn && !strobe.clearCnt) |=> $stable(cntQ));
  // R3: overflow bit changes only at a capture
  a_r3_ovf_only_capture: assert property (@(posedge clk) disable iff (!rstN || !unitEn)
    !strobe.doCapture |=> $stable(ovfQ));
  // R7: configuration locked while enabled
  a_r7_cfg_locked: assert property (@(posedge clk) disable iff (!rstN || !unitEn)
    strobe.cfgLock |=> ($stable(modeQ) && $stable(ratioQ[0]) && $stable(ratioQ[1])));
endmodule

// File: rtl/pulse_width_timer.sv
module pulse_width_timer
  import pwt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int RATIO_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              unitEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              startTrig,
  input  logic              stopTrig,
  input  logic              pinIn,
  output logic              irq
);
  pwtStrobe_t strobe;
  logic       lowLevel;

  pwt_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .unitEn    (unitEn),
    .startTrig (startTrig),
    .stopTrig  (stopTrig),
    .pinIn     (pinIn),
    .lowLevel  (lowLevel),
    .strobe    (strobe),
    .irq       (irq)
  );

  pwt_datapath #(.CNT_W(CNT_W), .RATIO_W(RATIO_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .unitEn   (unitEn),
    .strobe   (strobe),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .lowLevel (lowLevel)
  );
endmodule

// File: tb/test_pulse_width_timer.sv
module test_pulse_width_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        unitEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        startTrig = 1'b0;
  logic        stopTrig = 1'b0;
  logic        pinIn = 1'b0;
  logic        irq;

  int testCount = 0;
  int failCount = 0;
  int irqCount = 0;
  bit done = 1'b0;

  pulse_width_timer i_pulse_width_timer (
    .clk(clk), .rstN(rstN), .unitEn(unitEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .startTrig(startTrig),
    .stopTrig(stopTrig), .pinIn(pinIn), .irq(irq)
  );

  always #4 clk = ~clk;

  always @(negedge clk) if (irq) irqCount++;

  task automatic check(input string req, input int got, input int exp);
    testCount++;
    if (got != exp) begin
      failCount++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk); rdAddr = a; #1; v = int'(rdData);
  endtask

  task automatic arm();
    @(negedge clk); startTrig = 1'b1;
    @(negedge clk); startTrig = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic stopCh();
    @(negedge clk); stopTrig = 1'b1;
    @(negedge clk); stopTrig = 1'b0;
  endtask

  // pin held at lvl for w clocks, then returned
  task automatic pulse(input logic lvl, input int w);
    @(negedge clk); pinIn = lvl;
    repeat (w) @(negedge clk);
    pinIn = ~lvl;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    int v;
    rd(3'd0, v); check("R11 reset mode", v, 0);
    rd(3'd3, v); check("R11 reset counter", v, 0);
    rd(3'd4, v); check("R11 reset capture", v, 0);
    rd(3'd5, v); check("R11 reset status", v, 0);
    rd(3'd7, v); check("R12 unused address", v, 0);
  endtask

  task automatic t_high_width();
    int v, v2, irq0;
    wr(3'd0, 16'd0); wr(3'd1, 16'd0);
    arm();
    rd(3'd5, v); check("R1 enable set", v & 1, 1);
    irq0 = irqCount;
    @(negedge clk); pinIn = 1'b1;
    repeat (10) @(negedge clk);
    rd(3'd3, v); rd(3'd3, v2);
    check("R8 counter advances", (v2 > v) ? 1 : 0, 1);
    repeat (28) @(negedge clk);
    pinIn = 1'b0;
    repeat (6) @(negedge clk);
    rd(3'd4, v); check("R2 high width W=40", v, 39);
    check("R4 one irq per capture", irqCount - irq0, 1);
    rd(3'd5, v); check("R3 no overflow", (v >> 1) & 1, 0);
    rd(3'd3, v); repeat (10) @(negedge clk); rd(3'd3, v2);
    check("R5 counter holds after capture", v2, v);
    check("R5 hold value", v2, 39);
    // R1: re-arm keeps counter until a start edge
    arm();
    rd(3'd3, v); check("R1 counter kept until edge", v, 39);
  endtask

  task automatic t_cfg_lock();
    int v;
    wr(3'd0, 16'd3); wr(3'd1, 16'd9);
    rd(3'd0, v); check("R7 mode write ignored", v, 0);
    rd(3'd1, v); check("R7 ratio write ignored", v, 0);
    stopCh();
    rd(3'd5, v); check("R6 enable cleared", v & 1, 0);
    wr(3'd1, 16'd2);
    rd(3'd1, v); check("R7 write accepted when disabled", v, 2);
  endtask

  task automatic t_prescale_a();
    int v;
    arm();
    pulse(1'b1, 16);
    rd(3'd4, v); check("R2 ratio 2 W=16", v, 5);
    stopCh();
  endtask

  task automatic t_low_width();
    int v;
    wr(3'd0, 16'd2); wr(3'd1, 16'd0);
    @(negedge clk); pinIn = 1'b1;
    repeat (5) @(negedge clk);
    arm();
    pulse(1'b0, 7);
    rd(3'd4, v); check("R10 low width W=7", v, 6);
    stopCh();
    @(negedge clk); pinIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_clock_b();
    int v;
    wr(3'd0, 16'd1); wr(3'd2, 16'd3); wr(3'd1, 16'd0);
    arm();
    pulse(1'b1, 20);
    rd(3'd4, v); check("R9 source B ratio 3 W=20", v, 4);
    stopCh();
    wr(3'd0, 16'd0);
  endtask

  task automatic t_overflow_stop();
    int v, v2, irq0;
    arm();
    pulse(1'b1, 65540);
    rd(3'd4, v); check("R3 wrapped capture", v, 3);
    rd(3'd5, v); check("R3 overflow set", (v >> 1) & 1, 1);
    pulse(1'b1, 5);
    rd(3'd4, v); check("R3 short capture", v, 4);
    rd(3'd5, v); check("R3 overflow cleared", (v >> 1) & 1, 0);
    pulse(1'b1, 65537);
    rd(3'd5, v); check("R3 overflow set again", (v >> 1) & 1, 1);
    // stop in the middle of a measurement
    @(negedge clk); pinIn = 1'b1;
    repeat (30) @(negedge clk);
    stopCh();
    irq0 = irqCount;
    rd(3'd3, v); repeat (10) @(negedge clk); rd(3'd3, v2);
    check("R6 counter frozen by stop", v2, v);
    rd(3'd5, v); check("R6 overflow kept, enable clear", v, 2);
    @(negedge clk); pinIn = 1'b0;
    repeat (6) @(negedge clk);
    check("R6 no irq after stop", irqCount - irq0, 0);
    rd(3'd4, v); check("R6 capture unchanged", v, 0);
  endtask

  task automatic t_unit_off();
    int v;
    @(negedge clk); unitEn = 1'b0;
    wr(3'd0, 16'd3);
    rd(3'd5, v); check("R11 status cleared", v, 0);
    rd(3'd3, v); check("R11 counter cleared", v, 0);
    @(negedge clk); unitEn = 1'b1;
    rd(3'd0, v); check("R11 write blocked", v, 0);
    rd(3'd1, v); check("R11 ratio cleared", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); unitEn = 1'b1;
    t_reset();
    t_high_width();
    t_cfg_lock();
    t_prescale_a();
    t_low_width();
    t_clock_b();
    t_overflow_stop();
    t_unit_off();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end
endmodule